// File: doc/BRIEF.md
# Key-Protected Mode-Write Lock

This block guards the direction-mode registers of every GPIO bank in a chip. It holds one 32-bit control word. Software opens the guard by storing a fixed 16-bit magic value in the low half of that word. It closes the guard by storing zero there. While the guard is open, a single output, `mode_wr_grant`, is high. That output fans out to all the GPIO banks, and each bank lets its two mode registers be written only while it is high.

The control word sits in an 8-byte window that holds two 32-bit words. Word 0 is the lock word. Word 1 is reserved: it reads as zero and writes to it are dropped. A read of the lock word returns the open/closed status in bit 31 and zero in every other bit. The magic value is never echoed back.

Internally, a two-state machine holds the status. The state `ST_LOCKED` is entered at reset, and the state `ST_OPEN` means mode writes are allowed.
- The transition `T_GRANT` (ST_LOCKED to ST_OPEN) fires on a lock-word write whose key field equals the magic value.
- The transition `T_REVOKE` (ST_OPEN to ST_LOCKED) fires on a lock-word write whose key field is zero.
- Every other write keeps the current state. A magic write while open and a zero write while locked are self-loops.

Top module: `key_lock_gate`

## Requirements
- R1: During and after reset, before any write, the state is ST_LOCKED: `mode_wr_grant` is 0 and a read of word 0 (`addr`=0) returns 0x0000_0000.
- R2: A write to word 0 whose key field `wdata[15:0]` equals 0xD42F moves the block to ST_OPEN. `mode_wr_grant` is 1 from the first clock edge after the write.
- R3: A write to word 0 whose key field is 0x0000 moves the block to ST_LOCKED. `mode_wr_grant` is 0 from the first clock edge after the write.
- R4: A write to word 0 whose key field is neither 0xD42F nor 0x0000 leaves the state unchanged, from either state. Bits 31:16 of `wdata` never affect the outcome of a write.
- R5: A read of word 0 returns the status in bit 31 (1 = ST_OPEN). Bits 30:16 and 15:0 read as 0.
- R6: Word 1 (`addr`=1) reads as 0x0000_0000, and writes to it never change the state, whatever the key field holds.
- R7: `mode_wr_grant` is driven from the state register, and it always equals bit 31 of a word-0 read.
- R8: `rdata` is combinational on `addr`. A read of word 0 in the same cycle as a state-changing write returns the status from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 32-bit word index in the 8-byte window (0 = lock word, 1 = reserved) |
| wdata | input | 32 | Write data; only bits 15:0 (key field) are used |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rdata | output | 32 | Read data for the word selected by `addr` |
| mode_wr_grant | output | 1 | High while GPIO mode registers may be written |

## Verification
A write and a read of the lock word can fall in the same cycle. The bench provokes this by driving a granting write, and later a revoking write, to word 0 while `addr` stays on word 0. Within that cycle, `rdata` must show the status from before the write. After the next edge, both `rdata` bit 31 and `mode_wr_grant` must show the new status. Every key value from 0x0000 to 0xFFFF is swept from the state the reference model predicts, and a strided set of keys is applied from ST_OPEN. Each outcome is compared with a bench-side model in which only 0xD42F opens the lock and only 0x0000 closes it.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lk_state_t;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_GRANT  = 2'd1,
        CMD_REVOKE = 2'd2,
        CMD_OTHER  = 2'd3
    } lk_cmd_t;

endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode
    import lockreg_pkg::*;
#(
    parameter int              AW      = 1,
    parameter int              KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'hD42F
) (
    input  logic [AW-1:0]    addr,
    input  logic [KEY_W-1:0] key,
    input  logic             wr_en,
    output lk_cmd_t          cmd
);
    localparam logic [AW-1:0]    LOCK_WORD = '0;
    localparam logic [KEY_W-1:0] KEY_ZERO  = '0;

    logic hit;
    assign hit = wr_en && (addr == LOCK_WORD);

    always_comb begin
        if (!hit)
            cmd = CMD_IDLE;
        else if (key == KEY_VAL)
            cmd = CMD_GRANT;
        else if (key == KEY_ZERO)
            cmd = CMD_REVOKE;
        else
            cmd = CMD_OTHER;
    end
endmodule

// File: rtl/lockreg_fsm.sv
module lockreg_fsm
    import lockreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  lk_cmd_t cmd,
    output logic    open
);
    lk_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LOCKED;
        else
            state <= state_nx;
    end

    // transitions T_GRANT / T_REVOKE, all else self-loops
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: if (cmd == CMD_GRANT)  state_nx = ST_OPEN;
            ST_OPEN:   if (cmd == CMD_REVOKE) state_nx = ST_LOCKED;
            default:   state_nx = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_OPEN:   open = 1'b1;
            ST_LOCKED: open = 1'b0;
            default:   open = 1'b0;
        endcase
    end

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDLE || cmd == CMD_OTHER) |=> $stable(open))
        else $error("p_idle_hold_r4");
endmodule

// File: rtl/lockreg_rdmux.sv
module lockreg_rdmux #(
    parameter int AW         = 1,
    parameter int DATA_W     = 32,
    parameter int STATUS_BIT = 31
) (
    input  logic [AW-1:0]     addr,
    input  logic              open,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [AW-1:0] LOCK_WORD = '0;

    always_comb begin
        rdata = '0;
        if (addr == LOCK_WORD)
            rdata[STATUS_BIT] = open;
    end
endmodule

// File: rtl/key_lock_gate.sv
module key_lock_gate
    import lockreg_pkg::*;
#(
    parameter int               AW         = 1,
    parameter int               DATA_W     = 32,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] KEY_VAL    = 16'hD42F,
    parameter int               STATUS_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              mode_wr_grant
);
    lk_cmd_t cmd;
    logic    open;
    logic    unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:KEY_W];

    lockreg_decode #(.AW(AW), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_dec (
        .addr (addr),
        .key  (wdata[KEY_W-1:0]),
        .wr_en(wr_en),
        .cmd  (cmd)
    );

    lockreg_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .open (open)
    );

    lockreg_rdmux #(.AW(AW), .DATA_W(DATA_W), .STATUS_BIT(STATUS_BIT)) u_rd (
        .addr (addr),
        .open (open),
        .rdata(rdata)
    );

    assign mode_wr_grant = open;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !mode_wr_grant)
        else $error("p_reset_r1");

    p_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[KEY_W-1:0] == KEY_VAL) |=> mode_wr_grant)
        else $error("p_grant_r2");

    p_revoke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[KEY_W-1:0] == '0) |=> !mode_wr_grant)
        else $error("p_revoke_r3");

    p_other_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[KEY_W-1:0] != KEY_VAL && wdata[KEY_W-1:0] != '0)
        |=> $stable(mode_wr_grant))
        else $error("p_other_key_r4");

    p_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rdata) <= 1 && (rdata & ~(DATA_W'(1) << STATUS_BIT)) == '0)
        else $error("p_zero_bits_r5");

    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != '0) |=> $stable(mode_wr_grant))
        else $error("p_reserved_r6");

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata[STATUS_BIT] == mode_wr_grant))
        else $error("p_status_r7");
endmodule

// File: tb/key_lock_gate_test.sv
`timescale 1ns/1ps
module key_lock_gate_test;
    localparam logic [15:0] KEY = 16'hD42F;
    localparam logic [31:0] ST1 = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic        mode_wr_grant;

    int checks = 0;
    int errors = 0;
    bit model = 1'b0;

    always #2.5 clk = ~clk;

    key_lock_gate uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rdata(rdata), .mode_wr_grant(mode_wr_grant)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at a negedge; on return the edge has passed and outputs are settled
    task automatic wr(input logic [0:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = '0;
        if (a == 1'b0) begin
            if (d[15:0] == KEY) model = 1'b1;
            else if (d[15:0] == 16'h0000) model = 1'b0;
        end
        #0.5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1 grant in reset", {31'b0, mode_wr_grant}, 32'd0);
        chk("R1 rdata in reset", rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        chk("R1 grant after reset", {31'b0, mode_wr_grant}, 32'd0);
        chk("R1 rdata after reset", rdata, 32'd0);

        // same-cycle read and granting write
        @(negedge clk);
        addr = 1'b0; wdata = {16'h0000, KEY}; wr_en = 1'b1;
        #0.5;
        chk("R8 read during grant write", rdata, 32'd0);
        @(negedge clk);
        wr_en = 1'b0; model = 1'b1;
        #0.5;
        chk("R2 grant after key", {31'b0, mode_wr_grant}, 32'd1);
        chk("R5 status read open", rdata, ST1);
        chk("R7 grant matches status", {31'b0, mode_wr_grant}, {31'b0, rdata[31]});

        // reserved word
        addr = 1'b1;
        #0.5;
        chk("R6 reserved read", rdata, 32'd0);
        wr(1'b1, 32'h0000_0000);
        chk("R6 reserved zero write ignored", {31'b0, mode_wr_grant}, 32'd1);

        // same-cycle read and revoking write, upper bits set
        @(negedge clk);
        addr = 1'b0; wdata = 32'hABCD_0000; wr_en = 1'b1;
        #0.5;
        chk("R8 read during revoke write", rdata, ST1);
        @(negedge clk);
        wr_en = 1'b0; model = 1'b0;
        #0.5;
        chk("R3 revoke with upper bits", {31'b0, mode_wr_grant}, 32'd0);
        chk("R5 status read locked", rdata, 32'd0);

        wr(1'b1, {16'h0000, KEY});
        chk("R6 reserved key write ignored", {31'b0, mode_wr_grant}, 32'd0);
        wr(1'b0, 32'hFFFF_D42F);
        chk("R4 upper bits ignored on grant", {31'b0, mode_wr_grant}, 32'd1);
        wr(1'b0, 32'h0000_D42E);
        chk("R4 near key keeps open", {31'b0, mode_wr_grant}, 32'd1);
        wr(1'b0, 32'h0000_0000);
        chk("R3 revoke", {31'b0, mode_wr_grant}, 32'd0);

        // full key sweep from the modelled state
        for (int k = 0; k < 65536; k++) begin
            wr(1'b0, {16'(k ^ 16'h5A5A), 16'(k)});
            chk("R4 key sweep grant", {31'b0, mode_wr_grant}, {31'b0, model});
            chk("R5 key sweep read", rdata, model ? ST1 : 32'd0);
        end

        // strided keys from ST_OPEN
        for (int k = 1; k < 65536; k += 97) begin
            wr(1'b0, {16'h0000, KEY});
            wr(1'b0, {16'hFFFF, 16'(k)});
            chk("R4 sweep from open", {31'b0, mode_wr_grant}, {31'b0, model});
        end

        // reserved word sweep while locked
        wr(1'b0, 32'd0);
        for (int k = 0; k < 65536; k += 251) begin
            wr(1'b1, {16'h0000, 16'(k)});
            chk("R6 reserved sweep", {31'b0, mode_wr_grant}, 32'd0);
        end
        wr(1'b1, {16'h0000, KEY});
        chk("R6 reserved magic", {31'b0, mode_wr_grant}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule